// File: doc/BRIEF.md
# Single-Wire Bus Input Deglitcher

This block sits between the pad sample of a single-wire, open-drain bus and the time-slot logic of a bus slave. It runs on a fast system clock that oversamples the line. It hands the slot logic two things: a cleaned line level and a strobe one cycle wide that marks the start of every accepted time slot. The raw sample first passes through a synchronizer. A falling edge is then accepted only after a programmable low-pass qualification. That qualification is skipped when the bus runs at overdrive speed.

After every return of the line to high, a programmable hold-off window opens. Low excursions inside the window are ignored at either speed, because reflections and ringing on a long bus show up right after the rising edge. A low that is still present when the window closes is no longer treated as noise. It goes through the normal qualification and becomes a new slot start.

Both lengths are run-time inputs counted in system clock cycles. This lets firmware tune the filter to the oversampling ratio and the network size.

Top module: `swb_deglitch`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `line_level` is 1, `slot_start` is 0 and no hold-off window is open.
- R2: The raw input passes through two synchronizing flops. At overdrive speed with no window open, a low first captured at clock edge k makes `line_level` fall, and `slot_start` pulse, at edge k+2.
- R3: At standard speed (`speed_od` = 0), a low is accepted only once the synchronized line has been low for `filt_len` consecutive samples outside a hold-off window. A shorter low leaves `line_level` high and produces no strobe.
- R4: At overdrive speed (`speed_od` = 1), the qualification is bypassed. A single synchronized low sample outside a window is accepted on the next edge.
- R5: `slot_start` is high for exactly one cycle. It is high in precisely the cycles in which `line_level` has just changed from 1 to 0.
- R6: A return to high is not filtered. `line_level` rises on the edge after the synchronized line is seen high while the filtered level is low.
- R7: When `line_level` rises, a window of `hold_len` cycles opens. Synchronized low samples evaluated during it are ignored at both speeds and produce no strobe.
- R8: A low that is still present when the window closes starts qualification from zero on the first cycle after expiry. At overdrive speed it is accepted on the following edge.
- R9: A `filt_len` of 0 or 1 accepts a low after a single sample. A `hold_len` of 0 opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous reset, active high |
| line_raw | input | 1 | Raw sample of the bus line (asynchronous to clk) |
| speed_od | input | 1 | 0 = standard speed, 1 = overdrive speed |
| filt_len | input | FILT_W (4) | Number of consecutive low samples needed at standard speed |
| hold_len | input | HOLD_W (6) | Hold-off window length in cycles after a rising edge |
| line_level | output | 1 | Filtered line level |
| slot_start | output | 1 | One-cycle strobe marking an accepted falling edge |

## Verification
The bench goes after low pulses one sample shorter than the filter length and exactly as long. A design that counts one sample too many or too few would either miss real slots or pass glitches. It places glitches inside the hold-off window at both speeds. A design that applies the window only at standard speed would emit false strobes at overdrive. It also holds a low across the end of the window, where a design that discards such a low would lose a slot start and one that never ignores it would fire early. It measures the exact edge latency through the synchronizer at overdrive, and it exercises zero filter and zero window lengths, where off-by-one counters tend to wrap.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int unsigned FILT_W_DEF      = 4;
    localparam int unsigned HOLD_W_DEF      = 6;
    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned CMP_W           = 16;

    typedef enum logic {
        SPD_STD = 1'b0,
        SPD_OD  = 1'b1
    } speed_e;

    typedef struct packed {
        logic level;
        logic strobe;
    } out_state_t;

    localparam out_state_t OUT_IDLE = '{level: 1'b1, strobe: 1'b0};

    // True once the number of low samples seen (current one included)
    // has reached the requested run length.
    function automatic logic run_complete(input logic [CMP_W-1:0] seen,
                                          input logic [CMP_W-1:0] need);
        return seen >= need;
    endfunction

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/swb_fall_qual.sv
module swb_fall_qual
    import swb_pkg::*;
#(
    parameter int unsigned FILT_W = FILT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              line_low,
    input  speed_e            speed,
    input  logic [FILT_W-1:0] filt_len,
    output logic              accept
);
    logic [FILT_W-1:0] run_q;
    logic [CMP_W-1:0]  seen;
    logic              candidate;

    assign seen      = CMP_W'(run_q) + CMP_W'(1);
    assign candidate = enable && line_low;

    always_comb begin
        accept = 1'b0;
        if (candidate) begin
            if (speed == SPD_OD) begin
                accept = 1'b1;
            end else begin
                accept = run_complete(seen, CMP_W'(filt_len));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !candidate || accept) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + FILT_W'(1);
        end
    end
endmodule

// File: rtl/swb_holdoff.sv
module swb_holdoff #(
    parameter int unsigned HOLD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              active
);
    logic [HOLD_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= hold_len;
        end else if (left_q != '0) begin
            left_q <= left_q - HOLD_W'(1);
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/swb_deglitch.sv
module swb_deglitch
    import swb_pkg::*;
#(
    parameter int unsigned FILT_W      = FILT_W_DEF,
    parameter int unsigned HOLD_W      = HOLD_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_raw,
    input  logic              speed_od,
    input  logic [FILT_W-1:0] filt_len,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              line_level,
    output logic              slot_start
);
    logic       line_sync;
    logic       hold_on;
    logic       rise;
    logic       fall_ok;
    speed_e     speed_sel;
    out_state_t st_q, st_d;

    assign speed_sel = speed_od ? SPD_OD : SPD_STD;

    swb_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) sync_i (
        .clk(clk),
        .rst(rst),
        .d  (line_raw),
        .q  (line_sync)
    );

    assign rise = !st_q.level && line_sync;

    swb_holdoff #(
        .HOLD_W(HOLD_W)
    ) hold_i (
        .clk     (clk),
        .rst     (rst),
        .start   (rise),
        .hold_len(hold_len),
        .active  (hold_on)
    );

    swb_fall_qual #(
        .FILT_W(FILT_W)
    ) qual_i (
        .clk     (clk),
        .rst     (rst),
        .enable  (st_q.level && !hold_on),
        .line_low(!line_sync),
        .speed   (speed_sel),
        .filt_len(filt_len),
        .accept  (fall_ok)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (rise) begin
            st_d.level = 1'b1;
        end else if (fall_ok) begin
            st_d.level  = 1'b0;
            st_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= OUT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_level = st_q.level;
    assign slot_start = st_q.strobe;
endmodule

// File: rtl/swb_deglitch_chk.sv
module swb_deglitch_chk (
    input logic clk,
    input logic rst,
    input logic speed_od,
    input logic sync_ln,
    input logic hold_active,
    input logic level,
    input logic slot
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (level && !slot && !hold_active));

    assert_od_immediate_R4: assert property (@(posedge clk) disable iff (rst)
        (speed_od && level && !hold_active && !sync_ln) |=> slot);

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        slot |=> !slot);

    assert_strobe_with_fall_R5: assert property (@(posedge clk) disable iff (rst)
        slot |-> (!level && $past(level)));

    assert_fall_has_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(level) |-> slot);

    assert_rise_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (!level && sync_ln) |=> level);

    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        hold_active |=> !slot);

    assert_expiry_accept_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(hold_active) && speed_od && level && !sync_ln) |=> slot);
endmodule

bind swb_deglitch swb_deglitch_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .speed_od   (speed_od),
    .sync_ln    (line_sync),
    .hold_active(hold_on),
    .level      (line_level),
    .slot       (slot_start)
);

// File: tb/swb_deglitch_tb_top.sv
module swb_deglitch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 4;
    localparam int HW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line_raw = 1'b1;
    logic          speed_od = 1'b0;
    logic [FW-1:0] filt_len = 4'd3;
    logic [HW-1:0] hold_len = 6'd0;
    logic          line_level;
    logic          slot_start;

    int  checks = 0;
    int  errors = 0;
    int  strobes = 0;
    bit  done = 1'b0;
    string cur_req = "R1";

    // reference state (after the most recent edge)
    int m_s1 = 1, m_s2 = 1, m_lvl = 1, m_h = 0, m_l = 0, m_ss = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swb_deglitch dut_i (
        .clk       (clk),
        .rst       (rst),
        .line_raw  (line_raw),
        .speed_od  (speed_od),
        .filt_len  (filt_len),
        .hold_len  (hold_len),
        .line_level(line_level),
        .slot_start(slot_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected behaviour of one clock edge, from the requirements.
    task automatic model_step();
        int  ln;
        bit  rise, en, acc;
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_lvl = 1; m_h = 0; m_l = 0; m_ss = 0;
            return;
        end
        ln   = m_s2;
        rise = (m_lvl == 0) && (ln == 1);
        en   = (m_lvl == 1) && (m_h == 0);
        acc  = en && (ln == 0) && (speed_od || (m_l + 1 >= int'(filt_len)));
        if (en && ln == 0 && !acc) m_l = m_l + 1; else m_l = 0;
        if (rise) m_h = int'(hold_len); else if (m_h != 0) m_h = m_h - 1;
        m_ss = acc ? 1 : 0;
        if (rise) m_lvl = 1; else if (acc) m_lvl = 0;
        m_s2 = m_s1;
        m_s1 = int'(line_raw);
    endtask

    task automatic cycle(input logic raw);
        line_raw = raw;
        model_step();
        @(negedge clk);
        check(int'(line_level) == m_lvl, {cur_req, " level"}, int'(line_level), m_lvl);
        check(int'(slot_start) == m_ss, {cur_req, " strobe"}, int'(slot_start), m_ss);
        if (slot_start) strobes++;
    endtask

    task automatic drive_n(input logic raw, input int n);
        for (int i = 0; i < n; i++) cycle(raw);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        rst = 1'b1;
        drive_n(1'b0, 3);
        check(line_level === 1'b1 && slot_start === 1'b0, "R1 reset idle",
              int'(line_level), 1);
        rst = 1'b0;
        drive_n(1'b1, 6);

        // R2: synchronizer latency at overdrive
        cur_req = "R2";
        speed_od = 1'b1; hold_len = 6'd0;
        cycle(1'b0);
        check(line_level === 1'b1, "R2 edge k", int'(line_level), 1);
        cycle(1'b0);
        check(line_level === 1'b1, "R2 edge k+1", int'(line_level), 1);
        cycle(1'b0);
        check(line_level === 1'b0 && slot_start === 1'b1, "R2 edge k+2",
              int'(line_level), 0);
        // R5: strobe lasts one cycle
        cur_req = "R5";
        cycle(1'b0);
        check(slot_start === 1'b0 && line_level === 1'b0, "R5 single strobe",
              int'(slot_start), 0);
        // R6: unfiltered rise after synchronizer
        cur_req = "R6";
        cycle(1'b1); cycle(1'b1);
        check(line_level === 1'b0, "R6 before rise", int'(line_level), 0);
        cycle(1'b1);
        check(line_level === 1'b1, "R6 rise", int'(line_level), 1);
        drive_n(1'b1, 4);

        // R3: standard speed qualification
        cur_req = "R3";
        speed_od = 1'b0; filt_len = 4'd4;
        base = strobes;
        drive_n(1'b0, 3); drive_n(1'b1, 8);
        check(strobes == base, "R3 short low rejected", strobes - base, 0);
        base = strobes;
        drive_n(1'b0, 4); drive_n(1'b1, 8);
        check(strobes == base + 1, "R3 full low accepted", strobes - base, 1);

        // R4: overdrive bypasses filter
        cur_req = "R4";
        speed_od = 1'b1;
        base = strobes;
        drive_n(1'b0, 1); drive_n(1'b1, 8);
        check(strobes == base + 1, "R4 single sample", strobes - base, 1);

        // R7: glitch inside window, both speeds
        cur_req = "R7";
        hold_len = 6'd8;
        for (int sp = 0; sp < 2; sp++) begin
            speed_od = sp[0]; filt_len = 4'd1;
            drive_n(1'b0, 3); drive_n(1'b1, 3);
            base = strobes;
            drive_n(1'b0, 2); drive_n(1'b1, 14);
            check(strobes == base, "R7 glitch ignored", strobes - base, 0);
        end

        // R8: low spanning the end of the window
        cur_req = "R8";
        speed_od = 1'b1;
        drive_n(1'b0, 3); drive_n(1'b1, 3);
        base = strobes;
        drive_n(1'b0, 20);
        check(strobes == base + 1, "R8 accepted after window", strobes - base, 1);
        drive_n(1'b1, 14);

        // R9: zero lengths
        cur_req = "R9";
        speed_od = 1'b0; filt_len = 4'd0; hold_len = 6'd0;
        base = strobes;
        drive_n(1'b0, 1); drive_n(1'b1, 4);
        check(strobes == base + 1, "R9 filt 0", strobes - base, 1);
        base = strobes;
        drive_n(1'b0, 1); drive_n(1'b1, 4);
        check(strobes == base + 1, "R9 no window", strobes - base, 1);

        // random mix against the reference
        cur_req = "R3 random";
        void'($urandom(32'd20240611));
        for (int r = 0; r < 600; r++) begin
            if ($urandom % 8 == 0) begin
                speed_od = 1'($urandom % 2);
                filt_len = 4'($urandom % 8);
                hold_len = 6'($urandom % 16);
            end
            drive_n(1'($urandom % 2), 1 + int'($urandom % 10));
            if (r == 300) begin
                cur_req = "R1 mid reset";
                rst = 1'b1; drive_n(1'b0, 2);
                rst = 1'b0;
                check(line_level === 1'b1, "R1 after reset", int'(line_level), 1);
                cur_req = "R7 random";
            end
        end
        finish_run();
    end
endmodule